// File: doc/BRIEF.md
# Dual-Output Saw-Wave PWM Timer Channel

This block is a single channel of a general-purpose pulse-width timer. A 32-bit up-counter, advanced by a power-of-four clock prescaler, runs from zero to a programmable period and then wraps to zero. Each wrap closes one PWM cycle. Two output pins share that counter and that period. Each pin has its own compare register and its own 5-bit action code. The code sets the pin's level while the timer is idle, its level at each wrap, and what happens when the count equals the pin's compare value.

Software drives the channel over a plain 32-bit register bus, with an address, a write strobe, write data and combinational read data. The usual sequence is as follows. Stop the counter. Choose the prescaler and the action codes. Load the period and the compare values. Preload the counter with zero. Set the start bit. While the counter runs, the compare and period registers can be changed freely. The operating mode and the prescaler are locked until the counter is stopped again.

Top module: `pwm_saw_channel`

## Requirements
- R1: After reset, the control register reads 0, the counter reads 0, both compare registers and the period register read 0xFFFFFFFF, and both pins are low.
- R2: The registers sit at these byte offsets: control 0x2c, direction 0x30, pin control 0x34, counter 0x48, compare A 0x4c, compare B 0x50, period 0x64. Control reads back start at bit 0, mode at bits 18:16 and prescaler at bits 26:24. Direction keeps bits 1:0 and has no effect on counting. Every other offset, including 0x40, reads 0.
- R3: On each prescaler tick, the counter steps up by one. On a tick when it equals the period, it returns to 0 instead; that tick is the cycle end. A counter write loads the written value and wins over a tick. While stopped, the counter holds its value.
- R4: In a pin's 5-bit action code, bit 4 is the level held while the timer is not running. Bits 3:2 give the action at cycle end, and bits 1:0 give the action on a compare match (count equals compare value on a tick). The action values are 00 keep, 01 drive low, 10 drive high and 11 toggle. When both events fall on the same tick, the cycle-end action wins. A pin's new level appears one clock after the tick.
- R5: A control write updates the start bit every time. Its mode and prescaler fields are taken only if the start bit was clear before the write.
- R6: The counter counts only while the start bit is 1 and the mode is 0. Otherwise both pins are low, the counter holds and the prescaler restarts.
- R7: Prescaler code n gives one tick every 4^n clocks. Codes 6 and 7 behave as code 5.
- R8: Pin control bits 4:0 and 20:16 hold the action codes for pins A and B. Bits 8 and 24 enable those pins. A disabled pin is low.
- R9: If a compare value is above the period, that pin never matches. It stays at the level its cycle-end action gives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Channel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 8 | Register byte offset |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr |
| pwm_a | output | 1 | Output pin A |
| pwm_b | output | 1 | Output pin B |

## Verification
The two pins are run with opposite action codes, 0x1b and 0x07. This shows that the initial, cycle-end and match actions are decoded per pin and not shared. Further runs compare each pin's output with a behavioural model: one with the compare value equal to the period (the cycle-end action must win), one with the compare value above the period (there must be no match), and several with prescaler codes 0, 1 and 7 (the tick spacing and the clamp to 5). Control writes made while running, and a non-zero mode, check that the lock and the halt behave as specified and are not treated as plain stores.

// File: rtl/pwm_saw_pkg.sv
package pwm_saw_pkg;
  localparam int BUS_W  = 32;
  localparam int ADDR_W = 8;
  localparam int CODE_W = 5;
  localparam int NPIN   = 2;

  localparam logic [ADDR_W-1:0] OFS_CTRL   = 8'h2c;
  localparam logic [ADDR_W-1:0] OFS_DIR    = 8'h30;
  localparam logic [ADDR_W-1:0] OFS_PINCTL = 8'h34;
  localparam logic [ADDR_W-1:0] OFS_CNT    = 8'h48;
  localparam logic [ADDR_W-1:0] OFS_CMPA   = 8'h4c;
  localparam logic [ADDR_W-1:0] OFS_CMPB   = 8'h50;
  localparam logic [ADDR_W-1:0] OFS_PERIOD = 8'h64;

  typedef enum logic [1:0] {
    ACT_KEEP   = 2'b00,
    ACT_LOW    = 2'b01,
    ACT_HIGH   = 2'b10,
    ACT_TOGGLE = 2'b11
  } pin_act_e;

  function automatic logic act_level(input logic [1:0] act, input logic cur);
    case (pin_act_e'(act))
      ACT_KEEP: return cur;
      ACT_LOW:  return 1'b0;
      ACT_HIGH: return 1'b1;
      default:  return ~cur;
    endcase
  endfunction
endpackage

// File: rtl/pwm_cfg_regs.sv
module pwm_cfg_regs
  import pwm_saw_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [ADDR_W-1:0]             addr,
  input  logic                          we,
  input  logic [BUS_W-1:0]              wdata,
  output logic                          run,
  output logic [2:0]                    mode,
  output logic [2:0]                    presc,
  output logic [1:0]                    dir,
  output logic [NPIN-1:0][CODE_W-1:0]   code,
  output logic [NPIN-1:0]               pin_en,
  output logic [NPIN-1:0][CNT_W-1:0]    cmp,
  output logic [CNT_W-1:0]              period
);
  logic                        run_d;
  logic [2:0]                  mode_d, presc_d;
  logic [1:0]                  dir_d;
  logic [NPIN-1:0][CODE_W-1:0] code_d;
  logic [NPIN-1:0]             en_d;
  logic [NPIN-1:0][CNT_W-1:0]  cmp_d;
  logic [CNT_W-1:0]            per_d;

  always_comb begin
    run_d = run; mode_d = mode; presc_d = presc; dir_d = dir;
    code_d = code; en_d = pin_en; cmp_d = cmp; per_d = period;
    if (we) begin
      case (addr)
        OFS_CTRL: begin
          run_d = wdata[0];
          if (!run) begin
            mode_d  = wdata[18:16];
            presc_d = wdata[26:24];
          end
        end
        OFS_DIR:    dir_d = wdata[1:0];
        OFS_PINCTL: begin
          code_d[0] = wdata[4:0];
          en_d[0]   = wdata[8];
          code_d[1] = wdata[20:16];
          en_d[1]   = wdata[24];
        end
        OFS_CMPA:   cmp_d[0] = wdata[CNT_W-1:0];
        OFS_CMPB:   cmp_d[1] = wdata[CNT_W-1:0];
        OFS_PERIOD: per_d    = wdata[CNT_W-1:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run <= 1'b0; mode <= '0; presc <= '0; dir <= '0;
      code <= '0; pin_en <= '0; cmp <= '1; period <= '1;
    end else begin
      run <= run_d; mode <= mode_d; presc <= presc_d; dir <= dir_d;
      code <= code_d; pin_en <= en_d; cmp <= cmp_d; period <= per_d;
    end
  end

  // R5: mode and prescaler are frozen against writes made while running
  a_r5_cfg_locked: assert property (@(posedge clk) disable iff (!rst_n)
    (we && addr == OFS_CTRL && run) |=> ($stable(presc) && $stable(mode)));
endmodule

// File: rtl/pwm_prescaler.sv
module pwm_prescaler #(
  parameter int MAX_CODE = 5
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run_eff,
  input  logic [2:0] presc,
  output logic       tick
);
  localparam int PRE_W = 2 * MAX_CODE;

  logic [PRE_W-1:0] pre_q, pre_d;
  logic [2:0]       shift;
  logic [PRE_W:0]   mask_w;
  logic [PRE_W-1:0] mask;

  always_comb begin
    shift  = (int'(presc) > MAX_CODE) ? 3'(MAX_CODE) : presc;
    mask_w = ({{PRE_W{1'b0}}, 1'b1} << (2 * shift)) - 1'b1;
    mask   = mask_w[PRE_W-1:0];
    tick   = run_eff && ((pre_q & mask) == mask);
    pre_d  = run_eff ? pre_q + 1'b1 : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pre_q <= '0;
    else        pre_q <= pre_d;
  end

  // R7: a divided tick is never followed by another tick on the next clock
  a_r7_tick_spacing: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && presc != 3'd0) |=> !tick);
endmodule

// File: rtl/pwm_counter.sv
module pwm_counter #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic [CNT_W-1:0] period,
  input  logic             wr,
  input  logic [CNT_W-1:0] wdata,
  output logic [CNT_W-1:0] cnt,
  output logic             cyc_end
);
  logic [CNT_W-1:0] cnt_d;

  always_comb begin
    cyc_end = tick && (cnt == period);
    cnt_d   = cnt;
    if (wr)           cnt_d = wdata;
    else if (cyc_end) cnt_d = '0;
    else if (tick)    cnt_d = cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= cnt_d;
  end

  // R3: cycle end returns the count to zero
  a_r3_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_end && !wr) |=> (cnt == '0));
  // R3: an ordinary tick advances by exactly one
  a_r3_step: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !cyc_end && !wr) |=> (cnt == $past(cnt) + 1'b1));
endmodule

// File: rtl/pwm_pin.sv
module pwm_pin
  import pwm_saw_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run_eff,
  input  logic              tick,
  input  logic              cyc_end,
  input  logic [CNT_W-1:0]  cnt,
  input  logic [CNT_W-1:0]  cmp,
  input  logic [CODE_W-1:0] code,
  input  logic              en,
  output logic              pin
);
  logic lvl_q, lvl_d, match;

  always_comb begin
    match = tick && (cnt == cmp);
    lvl_d = lvl_q;
    if (!run_eff)     lvl_d = code[4];
    else if (cyc_end) lvl_d = act_level(code[3:2], lvl_q);
    else if (match)   lvl_d = act_level(code[1:0], lvl_q);
    pin = run_eff && en && lvl_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lvl_q <= 1'b0;
    else        lvl_q <= lvl_d;
  end

  // R4: cycle end with a drive-high action leaves the level high
  a_r4_end_high: assert property (@(posedge clk) disable iff (!rst_n)
    (run_eff && cyc_end && code[3:2] == 2'b10) |=> lvl_q);
  // R4: cycle end with a drive-low action leaves the level low
  a_r4_end_low: assert property (@(posedge clk) disable iff (!rst_n)
    (run_eff && cyc_end && code[3:2] == 2'b01) |=> !lvl_q);
endmodule

// File: rtl/pwm_saw_channel.sv
module pwm_saw_channel
  import pwm_saw_pkg::*;
#(
  parameter int CNT_W    = 32,
  parameter int MAX_CODE = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [BUS_W-1:0]  bus_wdata,
  output logic [BUS_W-1:0]  bus_rdata,
  output logic              pwm_a,
  output logic              pwm_b
);
  logic [1:0] rst_sync;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_int_n = rst_sync[1];

  logic                        run, run_eff, tick, cyc_end, cnt_wr;
  logic [2:0]                  mode, presc;
  logic [1:0]                  dir;
  logic [NPIN-1:0][CODE_W-1:0] code;
  logic [NPIN-1:0]             pin_en, pin_out;
  logic [NPIN-1:0][CNT_W-1:0]  cmp;
  logic [CNT_W-1:0]            period, cnt;

  pwm_cfg_regs #(.CNT_W(CNT_W)) u_regs (
    .clk(clk), .rst_n(rst_int_n), .addr(bus_addr), .we(bus_we),
    .wdata(bus_wdata), .run(run), .mode(mode), .presc(presc), .dir(dir),
    .code(code), .pin_en(pin_en), .cmp(cmp), .period(period)
  );

  assign run_eff = run && (mode == 3'd0);
  assign cnt_wr  = bus_we && (bus_addr == OFS_CNT);

  pwm_prescaler #(.MAX_CODE(MAX_CODE)) u_pre (
    .clk(clk), .rst_n(rst_int_n), .run_eff(run_eff), .presc(presc), .tick(tick)
  );

  pwm_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_int_n), .tick(tick), .period(period), .wr(cnt_wr),
    .wdata(bus_wdata[CNT_W-1:0]), .cnt(cnt), .cyc_end(cyc_end)
  );

  for (genvar gi = 0; gi < NPIN; gi++) begin : g_pin
    pwm_pin #(.CNT_W(CNT_W)) u_pin (
      .clk(clk), .rst_n(rst_int_n), .run_eff(run_eff), .tick(tick),
      .cyc_end(cyc_end), .cnt(cnt), .cmp(cmp[gi]), .code(code[gi]),
      .en(pin_en[gi]), .pin(pin_out[gi])
    );
  end

  assign pwm_a = pin_out[0];
  assign pwm_b = pin_out[1];

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      OFS_CTRL: begin
        bus_rdata[0]     = run;
        bus_rdata[18:16] = mode;
        bus_rdata[26:24] = presc;
      end
      OFS_DIR:    bus_rdata[1:0] = dir;
      OFS_PINCTL: begin
        bus_rdata[4:0]   = code[0];
        bus_rdata[8]     = pin_en[0];
        bus_rdata[20:16] = code[1];
        bus_rdata[24]    = pin_en[1];
      end
      OFS_CNT:    bus_rdata = BUS_W'(cnt);
      OFS_CMPA:   bus_rdata = BUS_W'(cmp[0]);
      OFS_CMPB:   bus_rdata = BUS_W'(cmp[1]);
      OFS_PERIOD: bus_rdata = BUS_W'(period);
      default: ;
    endcase
  end

  // R6: a halted channel (stopped or non-zero mode) keeps its count
  a_r6_halt_holds: assert property (@(posedge clk) disable iff (!rst_int_n)
    (!run_eff && !cnt_wr) |=> $stable(cnt));
endmodule

// File: tb/sim_pwm_saw_channel.sv
`timescale 1ns/1ps
module sim_pwm_saw_channel;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  bus_addr = 8'h00;
  logic        bus_we = 1'b0;
  logic [31:0] bus_wdata = 32'h0;
  logic [31:0] bus_rdata;
  logic        pwm_a, pwm_b;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  pwm_saw_channel u0 (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pwm_a(pwm_a), .pwm_b(pwm_b)
  );

  // ---------------- behavioural reference model ----------------
  int          m_sync;
  bit          m_run;
  int          m_mode, m_presc;
  logic [31:0] m_cnt, m_per;
  logic [31:0] m_cmp [2];
  logic [4:0]  m_code [2];
  bit          m_en [2];
  bit          m_lvl [2];
  int          m_pre;

  function automatic bit act(input logic [1:0] a, input bit cur);
    if (a == 2'd0) return cur;
    if (a == 2'd1) return 1'b0;
    if (a == 2'd2) return 1'b1;
    return !cur;
  endfunction

  function automatic bit m_running();
    return m_run && (m_mode == 0);
  endfunction

  task automatic m_reset();
    m_run = 0; m_mode = 0; m_presc = 0; m_cnt = 0; m_per = 32'hFFFF_FFFF;
    m_pre = 0;
    for (int i = 0; i < 2; i++) begin
      m_cmp[i] = 32'hFFFF_FFFF; m_code[i] = 0; m_en[i] = 0; m_lvl[i] = 0;
    end
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_sync = 0; m_reset();
    end else if (m_sync < 2) begin
      m_sync++;
    end else begin
      bit run_e, tk, ce, mt;
      int sh, span;
      run_e = m_running();
      sh    = (m_presc > 5) ? 5 : m_presc;
      span  = 1 << (2 * sh);
      tk    = run_e && ((m_pre % span) == span - 1);
      ce    = tk && (m_cnt == m_per);
      for (int i = 0; i < 2; i++) begin
        mt = tk && (m_cnt == m_cmp[i]);
        if (!run_e)   m_lvl[i] = m_code[i][4];
        else if (ce)  m_lvl[i] = act(m_code[i][3:2], m_lvl[i]);
        else if (mt)  m_lvl[i] = act(m_code[i][1:0], m_lvl[i]);
      end
      m_pre = run_e ? (m_pre + 1) % 1024 : 0;
      if (bus_we && bus_addr == 8'h48) m_cnt = bus_wdata;
      else if (ce) m_cnt = 0;
      else if (tk) m_cnt = m_cnt + 1;
      if (bus_we) begin
        case (bus_addr)
          8'h2c: begin
            if (!m_run) begin m_mode = bus_wdata[18:16]; m_presc = bus_wdata[26:24]; end
            m_run = bus_wdata[0];
          end
          8'h34: begin
            m_code[0] = bus_wdata[4:0];   m_en[0] = bus_wdata[8];
            m_code[1] = bus_wdata[20:16]; m_en[1] = bus_wdata[24];
          end
          8'h4c: m_cmp[0] = bus_wdata;
          8'h50: m_cmp[1] = bus_wdata;
          8'h64: m_per    = bus_wdata;
          default: ;
        endcase
      end
    end
  end

  // ---------------- checking ----------------
  task automatic chk(input string req, input string what,
                     input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, got, exp);
    end
  endtask

  // R4 / R8: cycle-by-cycle pin comparison against the model
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R4", "pin A vs model", {31'b0, pwm_a},
          {31'b0, m_running() && m_en[0] && m_lvl[0]});
      chk("R4", "pin B vs model", {31'b0, pwm_b},
          {31'b0, m_running() && m_en[1] && m_lvl[1]});
    end
  end

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a;
    #0.5;
    d = bus_rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      errors++; checks++;
      $display("FAIL watchdog: actual=expired expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] v, v2;
    bit seen_b_high, b_high;
    m_reset(); m_sync = 0;
    idle(3);
    rst_n = 1'b1;
    idle(4);

    // R1: reset state
    rd(8'h2c, v); chk("R1", "ctrl after reset", v, 32'h0);
    rd(8'h48, v); chk("R1", "counter after reset", v, 32'h0);
    rd(8'h4c, v); chk("R1", "compare A after reset", v, 32'hFFFF_FFFF);
    rd(8'h64, v); chk("R1", "period after reset", v, 32'hFFFF_FFFF);
    chk("R1", "pins after reset", {30'b0, pwm_a, pwm_b}, 32'h0);

    // R2: map, direction and unmapped offsets
    wr(8'h30, 32'h0000_0003);
    rd(8'h30, v); chk("R2", "direction readback", v, 32'h3);
    rd(8'h40, v); chk("R2", "offset 0x40 reads zero", v, 32'h0);
    rd(8'h00, v); chk("R2", "offset 0x00 reads zero", v, 32'h0);

    // main set-up: period 9, A at 3 with 0x1b, B at 6 with 0x07
    wr(8'h64, 32'd9);
    wr(8'h4c, 32'd3);
    wr(8'h50, 32'd6);
    wr(8'h34, 32'h0107_011b);
    rd(8'h34, v); chk("R8", "pin control readback", v, 32'h0107_011b);
    wr(8'h48, 32'd5);
    rd(8'h48, v); chk("R3", "counter preload", v, 32'd5);
    wr(8'h48, 32'd0);
    wr(8'h2c, 32'h0000_0001);
    chk("R4", "pin A starts at its initial high level", {31'b0, pwm_a}, 32'h1);
    chk("R4", "pin B starts at its initial low level", {31'b0, pwm_b}, 32'h0);
    seen_b_high = 0;
    for (int i = 0; i < 30; i++) begin
      @(negedge clk);
      if (pwm_b) seen_b_high = 1;
    end
    chk("R4", "pin B toggles high on its match", {31'b0, seen_b_high}, 32'h1);
    rd(8'h48, v); chk("R3", "live count", v, m_cnt);
    rd(8'h48, v2); chk("R3", "count advances by one", v2, v == 32'd9 ? 32'd0 : v + 1);

    // R9: compare B above the period never matches
    wr(8'h50, 32'd20);
    idle(12);
    b_high = 0;
    for (int i = 0; i < 30; i++) begin
      @(negedge clk);
      if (pwm_b) b_high = 1;
    end
    chk("R9", "pin B stays at cycle-end low", {31'b0, b_high}, 32'h0);

    // R4: compare equal to period, cycle-end action wins
    wr(8'h4c, 32'd9);
    idle(30);

    // R8: disable pin A while running
    wr(8'h34, 32'h0107_001b);
    idle(3);
    chk("R8", "disabled pin A is low", {31'b0, pwm_a}, 32'h0);
    wr(8'h4c, 32'd3);
    wr(8'h34, 32'h0107_011b);

    // R7 / R5: prescaler code 1, then a locked prescaler write
    wr(8'h2c, 32'h0000_0000);
    chk("R6", "stopped pins low", {30'b0, pwm_a, pwm_b}, 32'h0);
    rd(8'h48, v); idle(3); rd(8'h48, v2);
    chk("R6", "stopped counter holds", v2, v);
    wr(8'h48, 32'd0);
    wr(8'h2c, 32'h0100_0001);
    idle(60);
    rd(8'h48, v); chk("R7", "divide-by-4 count", v, m_cnt);
    wr(8'h2c, 32'h0201_0001);
    rd(8'h2c, v); chk("R5", "mode/prescaler ignored while running", v, 32'h0100_0001);
    idle(20);

    // R6: non-zero mode halts the channel
    wr(8'h2c, 32'h0000_0000);
    wr(8'h2c, 32'h0001_0001);
    rd(8'h2c, v); chk("R5", "mode taken while stopped", v, 32'h0001_0001);
    rd(8'h48, v); idle(5); rd(8'h48, v2);
    chk("R6", "mode 1 counter holds", v2, v);
    chk("R6", "mode 1 pins low", {30'b0, pwm_a, pwm_b}, 32'h0);

    // R7: code 7 behaves as 5 (1024 clocks per tick)
    wr(8'h2c, 32'h0000_0000);
    wr(8'h2c, 32'h0700_0000);
    wr(8'h48, 32'd0);
    wr(8'h2c, 32'h0700_0001);
    idle(1100);
    rd(8'h48, v); chk("R7", "code 7 clamped count", v, 32'd1);
    chk("R7", "code 7 count vs model", v, m_cnt);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule